// File: doc/BRIEF.md
# Pipelined SPI Read Host

This block drives a 16-bit framed SPI peripheral. Each request names a read or a write and a 14-bit register address. The block builds a command word that carries even parity and runs one chip-select window for each 16-bit frame. All setup, clock-phase, hold and spacing times are counted in system clock cycles. SCLK idles low. The host changes MOSI on the rising edge and samples MISO on the falling edge.

The peripheral answers a read one frame late. The word shifted in during a frame is the result of the read command sent in the frame before it. The host therefore keeps a one-entry tag with the address of the last read. When the next frame closes, it delivers that address together with the returned data and a status code. The status code reports a parity failure or an error flag set by the peripheral. Sometimes a read is waiting for its result and no request follows. The host then sends a dummy read of a fixed address to push the result out, and it drops the dummy's own result.

One address is a continuously updated angle. After a read of that address, the next read of the same address is held back by a programmable number of cycles. Reads of other addresses are not delayed.

Top module: `spi_frame_host`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, rsp_valid is 0 and req_ready is 1.
- R2: A read sends the command word with bit 15 = 1, a write sends it with bit 15 = 0. In both, bits 14:1 hold the address and bit 0 makes the count of ones over all 16 bits even. Bits go out MSB first on MOSI, which changes only while SCLK rises and stays stable through each falling edge.
- R3: Each SCLK high and low phase lasts at least HALF_CYC cycles. The first SCLK rise comes at least LEAD_CYC cycles after spi_cs_n falls.
- R4: spi_cs_n rises at least TRAIL_CYC cycles after the last SCLK fall. It stays high at least GAP_CYC cycles between frames.
- R5: The result of a read comes out in the cycle that spi_cs_n rises at the end of the following frame. rsp_valid is high for exactly that one cycle, rsp_addr is the read's address and rsp_data is bits 15:2 of the word sampled on MISO.
- R6: rsp_status is 0 when the response word is good. It is 1 when the response has an odd count of ones over all 16 bits, and 2 when the parity is good but bit 1 (the peripheral's error flag) is set. The parity failure takes priority.
- R7: No result is delivered for the first frame after reset, for write frames, or for dummy frames.
- R8: When a read result is pending, the host is idle and req_valid is low, the host sends one read of FLUSH_ADDR, delivers the pending result at the end of that frame, and then starts no further frame.
- R9: A write uses two consecutive frames. The first is the command word. The second is the data word, with data in bits 15:2, 0 in bit 1 and even parity in bit 0. No request is accepted between the two frames.
- R10: After the frame of a read of ANGLE_ADDR closes, a new read of ANGLE_ADDR starts no sooner than ANGLE_HOLD cycles after that spi_cs_n rise. Reads of any other address are not held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when req_valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Register address |
| req_wdata | input | 14 | Write data |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_addr | output | 14 | Address the result belongs to |
| rsp_data | output | 14 | Returned register data |
| rsp_status | output | 2 | 0 OK, 1 parity error, 2 peripheral error flag |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Host to peripheral data |
| spi_miso | input | 1 | Peripheral to host data |

## Verification
The assertions assume that spi_miso changes only after a rising SCLK edge. They also assume that req_addr and req_write hold steady while req_valid waits on req_ready, because the angle hold-off decision reads them in the same cycle. The bench models the peripheral so that it shifts its response on SCLK rise and captures MOSI on SCLK fall. The bench drives requests only on the falling edge of clk and keeps them steady until accepted. It injects parity and error-flag faults into single response words.

// File: rtl/spi_frame_host.sv
module spi_frame_host #(
  parameter int          LEAD_CYC   = 7,
  parameter int          HALF_CYC   = 7,
  parameter int          TRAIL_CYC  = 7,
  parameter int          GAP_CYC    = 7,
  parameter int          ANGLE_HOLD = 400,
  parameter logic [13:0] ANGLE_ADDR = 14'h3FFF,
  parameter logic [13:0] FLUSH_ADDR = 14'h3FFD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [13:0] req_addr,
  input  logic [13:0] req_wdata,
  output logic        rsp_valid,
  output logic [13:0] rsp_addr,
  output logic [13:0] rsp_data,
  output logic [1:0]  rsp_status,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int CW = $clog2(LEAD_CYC + HALF_CYC + TRAIL_CYC + GAP_CYC + 1);
  localparam int AW = $clog2(ANGLE_HOLD + 1);
  localparam logic [1:0] ST_OK = 2'd0, ST_PAR = 2'd1, ST_PEER = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_TRAIL, S_GAP} st_t;
  typedef enum logic [1:0] {F_READ, F_DUMMY, F_WCMD, F_WDATA} fr_t;

  st_t         st;
  fr_t         ftype, nt;
  logic [CW-1:0] cnt;
  logic [3:0]  bitn;
  logic [15:0] tx, rx, nw;
  logic [13:0] faddr, na, wd_val, pend_addr;
  logic        wd_pend, pend_live, go, done, take, flush, angle_block;
  logic [AW-1:0] angle_cnt;
  int unsigned lim;

  function automatic logic [15:0] cmd_word(input logic rd, input logic [13:0] a);
    cmd_word = {rd, a, ^{rd, a}};
  endfunction

  assign angle_block = !req_write && (req_addr == ANGLE_ADDR) && (angle_cnt != '0);
  assign req_ready   = (st == S_IDLE) && !wd_pend && !angle_block;
  assign take        = req_valid && req_ready;
  assign flush       = (st == S_IDLE) && !wd_pend && !req_valid && pend_live;

  always_comb begin
    case (st)
      S_LEAD:         lim = LEAD_CYC;
      S_HIGH, S_LOW:  lim = HALF_CYC;
      S_TRAIL:        lim = TRAIL_CYC;
      S_GAP:          lim = GAP_CYC;
      default:        lim = 1;
    endcase
  end
  assign done = (int'(cnt) == int'(lim) - 1);

  always_comb begin
    go = 1'b0;
    nw = '0;
    nt = F_READ;
    na = req_addr;
    if (st == S_IDLE) begin
      if (wd_pend) begin
        go = 1'b1;
        nw = {wd_val, 1'b0, ^{wd_val, 1'b0}};
        nt = F_WDATA;
        na = faddr;
      end else if (take) begin
        go = 1'b1;
        nw = cmd_word(!req_write, req_addr);
        nt = req_write ? F_WCMD : F_READ;
      end else if (flush) begin
        go = 1'b1;
        nw = cmd_word(1'b1, FLUSH_ADDR);
        nt = F_DUMMY;
        na = FLUSH_ADDR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bitn       <= '0;
      tx         <= '0;
      rx         <= '0;
      ftype      <= F_READ;
      faddr      <= '0;
      wd_pend    <= 1'b0;
      wd_val     <= '0;
      pend_live  <= 1'b0;
      pend_addr  <= '0;
      angle_cnt  <= '0;
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_data   <= '0;
      rsp_status <= ST_OK;
      spi_cs_n   <= 1'b1;
      spi_sclk   <= 1'b0;
      spi_mosi   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (angle_cnt != '0) angle_cnt <= angle_cnt - 1'b1;
      if (st == S_IDLE || done) cnt <= '0;
      else cnt <= cnt + 1'b1;

      case (st)
        S_IDLE: if (go) begin
          tx       <= nw;
          ftype    <= nt;
          faddr    <= na;
          spi_cs_n <= 1'b0;
          spi_mosi <= nw[15];
          bitn     <= 4'd15;
          st       <= S_LEAD;
          if (nt == F_WDATA) wd_pend <= 1'b0;
          if (nt == F_WCMD) begin
            wd_pend <= 1'b1;
            wd_val  <= req_wdata;
          end
        end
        S_LEAD: if (done) begin
          spi_sclk <= 1'b1;
          st       <= S_HIGH;
        end
        S_HIGH: if (done) begin
          spi_sclk <= 1'b0;
          rx       <= {rx[14:0], spi_miso};
          st       <= (bitn == 4'd0) ? S_TRAIL : S_LOW;
        end
        S_LOW: if (done) begin
          spi_sclk <= 1'b1;
          bitn     <= bitn - 4'd1;
          spi_mosi <= tx[bitn - 4'd1];
          st       <= S_HIGH;
        end
        S_TRAIL: if (done) begin
          spi_cs_n <= 1'b1;
          st       <= S_GAP;
          if (pend_live) begin
            rsp_valid  <= 1'b1;
            rsp_addr   <= pend_addr;
            rsp_data   <= rx[15:2];
            rsp_status <= (^rx) ? ST_PAR : (rx[1] ? ST_PEER : ST_OK);
          end
          pend_live <= (ftype == F_READ);
          pend_addr <= faddr;
          if (ftype == F_READ && faddr == ANGLE_ADDR) angle_cnt <= AW'(ANGLE_HOLD);
        end
        S_GAP: if (done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic          sclk_q, cs_q;
  logic [CW-1:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      run    <= '1;
    end else begin
      sclk_q <= spi_sclk;
      cs_q   <= spi_cs_n;
      if (spi_sclk != sclk_q || spi_cs_n != cs_q) run <= CW'(1);
      else if (run != '1) run <= run + 1'b1;
    end
  end

  a_r3_sclk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  a_r2_mosi_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> $stable(spi_mosi));
  a_r3_high_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_sclk && sclk_q) |-> (int'(run) >= HALF_CYC));
  a_r4_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && cs_q) |-> (int'(run) >= GAP_CYC));
  a_r5_rsp_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(spi_cs_n));
  a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3));

endmodule

// File: tb/tb_spi_frame_host.sv
module tb_spi_frame_host;
  localparam int LEAD = 7, HALF = 7, TRAIL = 7, GAP = 7, HOLD = 400;
  localparam logic [13:0] ANG = 14'h3FFF, FLU = 14'h3FFD;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [13:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 0;
  logic [13:0] rsp_addr, rsp_data;
  logic [1:0] rsp_status;

  always #4 clk = ~clk;

  spi_frame_host #(.LEAD_CYC(LEAD), .HALF_CYC(HALF), .TRAIL_CYC(TRAIL), .GAP_CYC(GAP),
    .ANGLE_HOLD(HOLD), .ANGLE_ADDR(ANG), .FLUSH_ADDR(FLU)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .rsp_status(rsp_status), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cmdw(input logic rd, input logic [13:0] a);
    return {rd, a, ^{rd, a}};
  endfunction
  function automatic logic [13:0] regval(input logic [13:0] a);
    return a ^ 14'h1A5C;
  endfunction

  // peripheral model
  logic [15:0] p_out = '0, p_in = '0;
  logic [15:0] wlog [64];
  int nlog = 0;
  bit p_wexp = 0, inj_par = 0, inj_ef = 0;
  always @(posedge spi_sclk) if (rst_n && !spi_cs_n) begin
    spi_miso = p_out[15];
    p_out = {p_out[14:0], 1'b0};
  end
  always @(negedge spi_sclk) if (rst_n && !spi_cs_n) p_in = {p_in[14:0], spi_mosi};
  always @(posedge spi_cs_n) if (rst_n) begin
    logic [15:0] w;
    w = '0;
    wlog[nlog] = p_in;
    nlog++;
    if (p_wexp) p_wexp = 0;
    else if (p_in[15]) begin
      w = {regval(p_in[14:1]), inj_ef, 1'b0};
      w[0] = ^w[15:1];
      if (inj_par) w[0] = ~w[0];
      inj_par = 0;
      inj_ef = 0;
    end else p_wexp = 1;
    p_out = w;
  end

  // timing and response monitor
  int cyc = 0, t_last = 0, nfall = 0, nrise = 0, nrsp = 0;
  int fall_t [64], rise_t [64];
  int min_lead = 1000, min_half = 1000, min_trail = 1000, min_gap = 1000;
  logic prev_cs = 1, prev_sclk = 0;
  logic [13:0] r_addr [64], r_data [64];
  logic [1:0] r_stat [64];
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (spi_cs_n != prev_cs) begin
        if (!spi_cs_n) begin
          if (nrise > 0 && cyc - t_last < min_gap) min_gap = cyc - t_last;
          fall_t[nfall] = cyc; nfall++;
        end else begin
          if (cyc - t_last < min_trail) min_trail = cyc - t_last;
          rise_t[nrise] = cyc; nrise++;
        end
        t_last = cyc;
      end else if (spi_sclk != prev_sclk) begin
        if (spi_sclk && !prev_cs && fall_t[nfall-1] == t_last) begin
          if (cyc - t_last < min_lead) min_lead = cyc - t_last;
        end else if (cyc - t_last < min_half) min_half = cyc - t_last;
        t_last = cyc;
      end
      if (rsp_valid) begin
        r_addr[nrsp] = rsp_addr; r_data[nrsp] = rsp_data; r_stat[nrsp] = rsp_status;
        nrsp++;
      end
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic send(input logic wr, input logic [13:0] a, input logic [13:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic quiet();
    repeat (1500) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(spi_cs_n == 1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 0, "R1 sclk", spi_sclk, 0);
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_pipelined_reads();
    int w0 = nlog, r0 = nrsp;
    send(0, 14'h0123, 0);
    send(0, 14'h2ABC, 0);
    quiet();
    chk(wlog[w0] == cmdw(1, 14'h0123), "R2 read cmd A", wlog[w0], cmdw(1, 14'h0123));
    chk(wlog[w0+1] == cmdw(1, 14'h2ABC), "R2 read cmd B", wlog[w0+1], cmdw(1, 14'h2ABC));
    chk(wlog[w0+2] == cmdw(1, FLU), "R8 flush cmd", wlog[w0+2], cmdw(1, FLU));
    chk(nlog == w0 + 3, "R8 no frame after flush", nlog, w0 + 3);
    chk(nrsp == r0 + 2, "R7 first frame discarded", nrsp, r0 + 2);
    chk(r_addr[r0] == 14'h0123, "R5 addr A", r_addr[r0], 14'h0123);
    chk(r_data[r0] == regval(14'h0123), "R5 data A", r_data[r0], regval(14'h0123));
    chk(r_stat[r0] == 0, "R6 status A ok", r_stat[r0], 0);
    chk(r_addr[r0+1] == 14'h2ABC, "R8 flushed addr B", r_addr[r0+1], 14'h2ABC);
    chk(r_data[r0+1] == regval(14'h2ABC), "R8 flushed data B", r_data[r0+1], regval(14'h2ABC));
  endtask

  task automatic t_fault(input bit par, input bit ef, input logic [13:0] a, input int exp_st, input string tag);
    int r0 = nrsp;
    if (par) inj_par = 1;
    if (ef) inj_ef = 1;
    send(0, a, 0);
    quiet();
    chk(nrsp == r0 + 1, {tag, " count"}, nrsp, r0 + 1);
    chk(r_addr[r0] == a, {tag, " addr"}, r_addr[r0], a);
    chk(r_stat[r0] == exp_st[1:0], {tag, " status"}, r_stat[r0], exp_st);
  endtask

  task automatic t_write();
    int w0 = nlog, r0 = nrsp;
    logic [15:0] dw;
    dw = {14'h2D71, 1'b0, ^{14'h2D71, 1'b0}};
    send(1, 14'h0042, 14'h2D71);
    quiet();
    chk(wlog[w0] == cmdw(0, 14'h0042), "R9 write cmd", wlog[w0], cmdw(0, 14'h0042));
    chk(wlog[w0+1] == dw, "R9 write data word", wlog[w0+1], dw);
    chk(nlog == w0 + 2, "R9 two frames", nlog, w0 + 2);
    chk(nrsp == r0, "R7 no result for write", nrsp, r0);
  endtask

  task automatic t_angle();
    int k = nlog, r0 = nrsp;
    send(0, ANG, 0);
    send(0, ANG, 0);
    quiet();
    chk(fall_t[k+1] - rise_t[k] >= HOLD, "R10 angle hold", fall_t[k+1] - rise_t[k], HOLD);
    chk(r_addr[r0] == ANG && r_stat[r0] == 0, "R5 angle result", r_addr[r0], ANG);
    k = nlog;
    send(0, ANG, 0);
    send(0, 14'h0010, 0);
    quiet();
    chk(fall_t[k+1] - rise_t[k] < HOLD, "R10 other addr not held", fall_t[k+1] - rise_t[k], GAP);
  endtask

  task automatic t_timing();
    chk(min_lead >= LEAD, "R3 lead", min_lead, LEAD);
    chk(min_half >= HALF, "R3 half phase", min_half, HALF);
    chk(min_trail >= TRAIL, "R4 trail", min_trail, TRAIL);
    chk(min_gap >= GAP, "R4 gap", min_gap, GAP);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pipelined_reads();
    t_fault(1, 0, 14'h0555, 1, "R6 parity error");
    t_fault(0, 1, 14'h0777, 2, "R6 peer error");
    t_fault(1, 1, 14'h0888, 1, "R6 parity priority");
    t_write();
    t_angle();
    t_timing();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule